// File: doc/BRIEF.md
# Fractional-Rate 64-bit Time Counter

This block keeps a 64-bit count of elapsed time that runs from the block's own clock. The tick rate does not need to be an integer fraction of that clock. On every clock, a 32-bit rate word is added into a remainder accumulator. Each whole multiple of 2^31 that the sum reaches advances the count by one and is removed from the remainder. What is left is carried into the next clock. The average tick rate is therefore clock frequency × rate / 2^31.

For example, with a 19.2 MHz clock the reset rate word 0x06AAAAAB gives a 1 MHz tick, and the rate word 0x42AAAAAB gives a 10 MHz tick.

Software reaches the block through a small register port. The interface has a write strobe, a read strobe, a two-bit word address and 32-bit data, and read data is combinational. The 64-bit count appears as two 32-bit words.

- **Reading.** Software reads the low word first, then the high word. Each low-word read copies the high half into a holding register, and the high-word read returns that copy. A carry from low to high between the two reads therefore cannot tear the value.
- **Writing.** Software writes the low word first, into a staging register, then the high word. The high-word write loads all 64 bits in one edge.

Top module: `frac_timebase`

## Requirements
- R1: While `rst_n` is low, the block resets asynchronously: the count is zero, the remainder is zero and the rate word is 0x06AAAAAB.
- R2: On every clock edge out of reset, the rate word is added to the 31-bit remainder. The count grows by the number of whole 2^31 units in that sum, which can be 0, 1 or 2, and the remainder keeps the rest. Starting from zero, after N edges at rate P the count is therefore floor(N·P / 2^31).
- R3: Word addresses are: 0 = rate word (read/write), 1 = count bits 31:0, 2 = count bits 63:32, 3 = unused. Address 3 reads as zero and writes to it change nothing. A rate write is used from the edge after the one that stores it.
- R4: A read of address 1 returns the live low word and, at that clock edge, copies the live high word into a holding register. A read of address 2 returns the held copy, not the live high word.
- R5: A write to address 1 only stages its data. The running count is not changed by it.
- R6: A write to address 2 while low data is staged replaces the whole count with {written data, staged data} at that edge, instead of that edge's increment. It also clears the staged state. Counting resumes on the next edge.
- R7: A write to address 2 with nothing staged is ignored, and the count keeps running.
- R8: A carry out of bit 31 of the count increments bit 32, so the 64-bit value counts without a break across the word boundary.
- R9: While `rd_en` is low, `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one accumulation per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational, zero when not reading |

## Verification
The rate path is tried with four rate words:

- The reset word, where most edges carry nothing.
- The 10 MHz word, which carries about every other edge.
- Exactly 2^31, which gives one tick per edge and lets loaded values be predicted to the cycle.
- The all-ones word, which carries two units on most edges.

Comparing each case against floor(sum / 2^31) separates correct remainder handling from truncation and from a carry path only one bit wide. A value loaded just below a 2^32 boundary, read as a split pair before and after the rollover, tells the held high word apart from the live one. Lone low-word and lone high-word writes check that staging neither changes the count early nor lets an unmatched high write through.

// File: rtl/frac_timebase.sv
`timescale 1ns/1ps
module frac_timebase #(
  parameter int          DW           = 32,
  parameter logic [31:0] PRESCALE_RST = 32'h06AAAAAB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int CW = 2 * DW;
  localparam logic [1:0] A_RATE = 2'd0;
  localparam logic [1:0] A_LO   = 2'd1;
  localparam logic [1:0] A_HI   = 2'd2;

  logic [DW-1:0] prescale, stage, hold;
  logic [DW-2:0] acc;
  logic [CW-1:0] count;
  logic          staged;
  logic [DW:0]   sum;

  assign sum = {2'b00, acc} + {1'b0, prescale};

  wire wr_rate = wr_en && (addr == A_RATE);
  wire wr_lo   = wr_en && (addr == A_LO);
  wire wr_hi   = wr_en && (addr == A_HI);
  wire load    = wr_hi && staged;
  wire rd_lo   = rd_en && (addr == A_LO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prescale <= DW'(PRESCALE_RST);
      acc      <= '0;
      count    <= '0;
      stage    <= '0;
      staged   <= 1'b0;
      hold     <= '0;
    end else begin
      acc <= sum[DW-2:0];
      if (load) count <= {wdata, stage};
      else      count <= count + CW'(sum[DW:DW-1]);
      if (wr_rate) prescale <= wdata;
      if (wr_lo) begin
        stage  <= wdata;
        staged <= 1'b1;
      end else if (wr_hi) begin
        staged <= 1'b0;
      end
      if (rd_lo) hold <= count[CW-1:DW];
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        A_RATE:  rdata = prescale;
        A_LO:    rdata = count[DW-1:0];
        A_HI:    rdata = hold;
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/frac_timebase_chk.sv
`timescale 1ns/1ps
module frac_timebase_chk #(
  parameter int          DW           = 32,
  parameter logic [31:0] PRESCALE_RST = 32'h06AAAAAB
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic            rd_en,
  input logic [1:0]      addr,
  input logic [DW-1:0]   wdata,
  input logic [DW-1:0]   rdata,
  input logic [DW-1:0]   prescale,
  input logic [DW-1:0]   stage,
  input logic [DW-1:0]   hold,
  input logic [2*DW-1:0] count,
  input logic            staged
);
  // R1
  reset_vals_chk: assert property (@(posedge clk)
    (rst_n && !$past(rst_n)) |-> (count == '0 && prescale == DW'(PRESCALE_RST)));

  // R2
  step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 2'd2 && staged) |=> ((count - $past(count)) <= (2*DW)'(2)));

  // R6
  atomic_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd2 && staged) |=> (count == {$past(wdata), $past(stage)} && !staged));

  // R5
  stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd1) |=> (staged && stage == $past(wdata)));

  // R4
  snapshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd1) |=> (hold == $past(count[2*DW-1:DW])));

  // R7
  orphan_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd2 && !staged) |=> !staged);

  // R9
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rdata == '0));
endmodule

bind frac_timebase frac_timebase_chk #(.DW(DW), .PRESCALE_RST(PRESCALE_RST)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .prescale(prescale), .stage(stage),
  .hold(hold), .count(count), .staged(staged)
);

// File: tb/tb_frac_timebase.sv
`timescale 1ns/1ps
module tb_frac_timebase;
  localparam longint unsigned P0 = 64'h06AAAAAB;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int checks = 0;
  int fails  = 0;
  longint unsigned ecnt = 0;
  longint unsigned last_edge = 0;

  always #2 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) ecnt <= 0;
    else        ecnt <= ecnt + 1;

  frac_timebase dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  task automatic check(input string req, input longint unsigned got, input longint unsigned exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    last_edge = ecnt;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d, output longint unsigned e);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1;
    d = rdata;
    e = ecnt;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  function automatic longint unsigned ticks(input longint unsigned e, input longint unsigned w,
                                            input longint unsigned p);
    return (w * P0 + (e - w) * p) >> 31;
  endfunction

  task automatic t_reset_state();
    logic [31:0] d; longint unsigned e;
    @(negedge clk);
    rst_n = 1'b0;
    bus_read(2'd0, d, e); check("R1 rate word in reset", d, P0);
    bus_read(2'd1, d, e); check("R1 count low in reset", d, 0);
    bus_read(2'd2, d, e); check("R1 held high in reset", d, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_default_rate();
    logic [31:0] lo, hi; longint unsigned e, e2, exp;
    do_reset();
    repeat (2000) @(negedge clk);
    bus_read(2'd1, lo, e);
    exp = ticks(e, e, P0);
    check("R2 default rate low word", lo, exp & 64'hFFFFFFFF);
    bus_read(2'd2, hi, e2);
    check("R2 default rate high word", hi, exp >> 32);
  endtask

  task automatic t_rate(input string req, input longint unsigned p);
    logic [31:0] d, lo; longint unsigned e, w, exp;
    do_reset();
    bus_write(2'd0, p[31:0]);
    w = last_edge;
    bus_read(2'd0, d, e);
    check("R3 rate word readback", d, p);
    repeat (1500) @(negedge clk);
    bus_read(2'd1, lo, e);
    exp = ticks(e, w, p);
    check(req, lo, exp & 64'hFFFFFFFF);
  endtask

  task automatic t_split_access();
    logic [31:0] d; longint unsigned e, L, ecur, v;
    do_reset();
    bus_write(2'd0, 32'h80000000);
    bus_write(2'd1, 32'hFFFFFFF0);
    bus_read(2'd1, d, e);
    check("R5 staged low does not change count", d, ticks(e, last_edge - 2, 64'h80000000) & 64'hFFFFFFFF);
    bus_write(2'd2, 32'h00000001);
    L = last_edge;
    v = 64'h00000001_FFFFFFF0;
    bus_read(2'd1, d, e);
    check("R6 load then resume count", d, (v + (e - L)) & 64'hFFFFFFFF);
    repeat (30) @(negedge clk);
    bus_read(2'd2, d, e);
    check("R4 high read returns held copy", d, 1);
    bus_read(2'd1, d, e);
    check("R8 low word after rollover", d, (v + (e - L)) & 64'hFFFFFFFF);
    bus_read(2'd2, d, ecur);
    check("R8 high word after rollover", d, (v + (e - L)) >> 32);
    bus_write(2'd2, 32'hDEAD0000);
    bus_read(2'd1, d, e);
    check("R7 lone high write ignored (low)", d, (v + (e - L)) & 64'hFFFFFFFF);
    bus_read(2'd2, d, ecur);
    check("R7 lone high write ignored (high)", d, (v + (e - L)) >> 32);
  endtask

  task automatic t_unused_and_idle();
    logic [31:0] d; longint unsigned e;
    do_reset();
    bus_read(2'd3, d, e);
    check("R3 unused address reads zero", d, 0);
    bus_write(2'd3, 32'h12345678);
    bus_read(2'd0, d, e);
    check("R3 unused write leaves rate word", d, P0);
    bus_read(2'd1, d, e);
    check("R3 unused write leaves count", d, ticks(e, e, P0) & 64'hFFFFFFFF);
    @(negedge clk);
    addr = 2'd0;
    #1;
    check("R9 rdata zero when idle", rdata, 0);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset_state();
    t_default_rate();
    t_rate("R2 ten-MHz rate word", 64'h42AAAAAB);
    t_rate("R2 all-ones rate, double carries", 64'hFFFFFFFF);
    t_rate("R2 exact one tick per edge", 64'h80000000);
    t_split_access();
    t_unused_and_idle();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule